// File: doc/BRIEF.md
# Register and Memory Write-Protection Controller

This block sits between a serial-bus command decoder and a small configuration store. The store holds a handful of control registers, a fault register, a reset-status register and a 256-byte nonvolatile array. The decoder hands the block one byte per clock. It marks the first byte of each command, and says whether the command is a read or a write and whether it targets register space or the array. For every write byte, the block decides whether the byte is committed to the store or silently dropped. For every read byte, it returns the addressed value.

The block applies three layers of protection. The first is a volatile arm/disarm latch, which is toggled only by exact byte values written to the latch-control register. The second is a two-bit block-protect field that fences off the top quarter, the top half or all of the array. The third is a hardware lock, which is the AND of an external pin and a stored lock-enable bit. When the hardware lock is active, the configuration registers are frozen, including the lock-enable bit itself. The fault and reset-status registers are written without any of these checks. A simple register-file model stands in for the nonvolatile cells.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset, the latch is clear. `commit_o`, `drop_o` and `rd_valid_o` are low. Configuration register 1 and every array byte read back as 00h.
- R2: A first-byte write of 80h to register 0 sets the latch, and a write of 00h clears it. Both are reported as commits. Any other value written to register 0 is dropped and leaves the latch unchanged. Reading register 0 returns the latch in bit 7, with zeros in the other bits.
- R3: While the latch is clear, every write to the array and to registers 1 to 4 is dropped.
- R4: Writes to register 5 (fault) and register 6 (reset status) always commit, whatever the latch, pin and protect settings.
- R5: Register 1 bits [1:0] select array protection. 00 protects nothing. 01 protects C0h–FFh. 10 protects 80h–FFh. 11 protects 00h–FFh. A write to a protected byte is dropped even with the latch set.
- R6: The hardware lock is active only when `wp_pin_i` is high and register 1 bit 7 is set. While it is active, writes to registers 1 to 4 are dropped. While it is inactive and the latch is set, those writes commit.
- R7: Under the hardware lock, with the latch set, unprotected array bytes remain writable.
- R8: Within an array write command, each byte is checked on its own. The address advances by one after each byte and wraps within the 16-byte page, so the upper four address bits never change.
- R9: A register write changes one byte only. Any byte after the first in a register write command is dropped. A write to register 7, which does not exist, is dropped.
- R10: Each write byte produces exactly one of `commit_o` or `drop_o`, one clock after it is presented. A commit carries the target address and data. For a register, the address is the 3-bit register number, zero-extended.
- R11: Each read byte produces `rd_valid_o` with `rd_data_o` one clock later. An array read advances the address by one and wraps from FFh to 00h. A register read repeats the same register. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_pin_i | input | 1 | External write-protect pin level |
| op_valid_i | input | 1 | A byte operation is presented this cycle |
| op_first_i | input | 1 | First byte of a command; loads the address |
| op_write_i | input | 1 | 1 = write byte, 0 = read byte |
| op_array_i | input | 1 | 1 = array space, 0 = register space |
| op_addr_i | input | 8 | Start address, used on the first byte (registers use bits [2:0]) |
| op_data_i | input | 8 | Write data |
| commit_o | output | 1 | Previous-cycle write byte was accepted |
| commit_array_o | output | 1 | Reported byte targeted the array |
| commit_addr_o | output | 8 | Address of the reported byte |
| commit_data_o | output | 8 | Data of the reported byte |
| drop_o | output | 1 | Previous-cycle write byte was ignored |
| rd_valid_o | output | 1 | Previous-cycle read byte result is valid |
| rd_data_o | output | 8 | Read result |

## Verification
Every result of this block is due exactly one clock after the byte that causes it. This holds for the commit or drop verdict with its address and data, for the read value, and for the effect of a latch or configuration change on the byte that follows. The bench drives each byte on a falling edge and checks the outputs on the next falling edge, after the single rising edge that registers them. Each new byte is presented only after that check, so every verdict is compared against a reference model that already includes all earlier commits.

// File: rtl/wprot_pkg.sv
// Shared constants for the write-protection controller.
// Assumes an 8-bit data path, because the latch arm/disarm codes are full bytes.
package wprot_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int PAGE_W = 4;
    localparam int REG_W  = 3;

    typedef enum logic [REG_W-1:0] {
        RG_LATCH = 3'd0,
        RG_CFG1  = 3'd1,
        RG_CFG2  = 3'd2,
        RG_CFG3  = 3'd3,
        RG_CFG4  = 3'd4,
        RG_FAULT = 3'd5,
        RG_RSTAT = 3'd6,
        RG_NONE  = 3'd7
    } reg_id_e;

    localparam logic [7:0] LATCH_ARM    = 8'h80;
    localparam logic [7:0] LATCH_DISARM = 8'h00;
    localparam int         LOCK_EN_BIT  = 7;
endpackage

// File: rtl/wprot_addr_seq.sv
// Address sequencer: selects the byte address for the current operation.
// It loads the start address on a command's first byte. After an array write
// byte it steps within the page; after an array read byte it steps linearly
// across the whole array. Register bytes keep the address unchanged.
module wprot_addr_seq #(
    parameter int AW = 8,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          first_i,
    input  logic          write_i,
    input  logic          array_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] cur_o
);
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] nxt;

    // Address in use this cycle
    assign cur_o = first_i ? addr_i : ptr_q;

    // Successor address for the active mode
    always_comb begin
        nxt = cur_o;
        if (array_i && write_i)
            nxt = {cur_o[AW-1:PW], cur_o[PW-1:0] + {{(PW-1){1'b0}}, 1'b1}};
        else if (array_i)
            nxt = cur_o + {{(AW-1){1'b0}}, 1'b1};
    end

    // Pointer register
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (step_i) ptr_q <= nxt;
    end
endmodule

// File: rtl/wprot_policy.sv
// Protection policy: a purely combinational verdict for one write byte.
// It assumes the latch, protect field and lock-enable values reflect all
// bytes committed before this one.
module wprot_policy
    import wprot_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          first_i,
    input  logic          array_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic          latch_i,
    input  logic [1:0]    bp_i,
    input  logic          lock_en_i,
    input  logic          pin_i,
    output logic          accept_o,
    output logic          arm_o,
    output logic          disarm_o,
    output logic          hw_lock_o
);
    logic    fenced;
    reg_id_e rid;

    assign hw_lock_o = pin_i & lock_en_i;
    assign rid       = reg_id_e'(addr_i[REG_W-1:0]);

    // Block-protect decode: top quarter, top half or everything
    always_comb begin
        unique case (bp_i)
            2'd0:    fenced = 1'b0;
            2'd1:    fenced = &addr_i[AW-1 -: 2];
            2'd2:    fenced = addr_i[AW-1];
            default: fenced = 1'b1;
        endcase
    end

    // Verdict and latch control
    always_comb begin
        accept_o = 1'b0;
        arm_o    = 1'b0;
        disarm_o = 1'b0;
        if (array_i) begin
            accept_o = latch_i & ~fenced;
        end else if (first_i) begin
            unique case (rid)
                RG_LATCH: begin
                    arm_o    = (data_i == LATCH_ARM);
                    disarm_o = (data_i == LATCH_DISARM);
                    accept_o = arm_o | disarm_o;
                end
                RG_CFG1, RG_CFG2, RG_CFG3, RG_CFG4: accept_o = latch_i & ~hw_lock_o;
                RG_FAULT, RG_RSTAT:                 accept_o = 1'b1;
                default:                            accept_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/wprot_store.sv
// Storage model: the arm latch, registers 1..6 and the byte array,
// with a registered read port. The nonvolatile cells are modelled as
// flops that clear on reset.
module wprot_store
    import wprot_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic          arm_i,
    input  logic          disarm_i,
    input  logic          rd_en_i,
    input  logic          array_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          latch_o,
    output logic [1:0]    bp_o,
    output logic          lock_en_o,
    output logic          rd_valid_o,
    output logic [DW-1:0] rd_data_o
);
    localparam int DEPTH = 2 ** AW;
    localparam int NREG  = 2 ** REG_W;

    logic [DW-1:0] mem_q  [DEPTH];
    logic [DW-1:0] regs_q [NREG];
    logic          latch_q;
    logic [DW-1:0] reg_view;
    logic [REG_W-1:0] rid;

    assign rid       = addr_i[REG_W-1:0];
    assign latch_o   = latch_q;
    assign bp_o      = regs_q[RG_CFG1][1:0];
    assign lock_en_o = regs_q[RG_CFG1][LOCK_EN_BIT];

    // Volatile arm latch
    always_ff @(posedge clk) begin
        if (!rst_n)                   latch_q <= 1'b0;
        else if (wr_en_i && arm_i)    latch_q <= 1'b1;
        else if (wr_en_i && disarm_i) latch_q <= 1'b0;
    end

    // Array cells
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en_i && array_i) begin
            mem_q[addr_i] <= data_i;
        end
    end

    // Register cells (0 is the latch and 7 is unmapped, so neither is stored)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (wr_en_i && !array_i && rid != RG_LATCH && rid != RG_NONE) begin
            regs_q[rid] <= data_i;
        end
    end

    // Register read view
    always_comb begin
        if (rid == RG_LATCH)     reg_view = {latch_q, {(DW-1){1'b0}}};
        else if (rid == RG_NONE) reg_view = '0;
        else                     reg_view = regs_q[rid];
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_en_i;
            if (rd_en_i) rd_data_o <= array_i ? mem_q[addr_i] : reg_view;
        end
    end
endmodule

// File: rtl/wprot_ctrl.sv
// Write-protection controller top. It takes one byte operation per clock
// from a command decoder and reports a commit or drop verdict for each
// write byte, and the data for each read byte, one clock later.
module wprot_ctrl
    import wprot_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int PW = PAGE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wp_pin_i,
    input  logic          op_valid_i,
    input  logic          op_first_i,
    input  logic          op_write_i,
    input  logic          op_array_i,
    input  logic [AW-1:0] op_addr_i,
    input  logic [DW-1:0] op_data_i,
    output logic          commit_o,
    output logic          commit_array_o,
    output logic [AW-1:0] commit_addr_o,
    output logic [DW-1:0] commit_data_o,
    output logic          drop_o,
    output logic          rd_valid_o,
    output logic [DW-1:0] rd_data_o
);
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] rep_addr;
    logic          accept, arm, disarm, hw_lock;
    logic          latch_q, lock_en;
    logic [1:0]    bp;
    logic          wr_byte, wr_en;

    assign wr_byte  = op_valid_i & op_write_i;
    assign wr_en    = wr_byte & accept;
    assign rep_addr = op_array_i ? cur_addr : {{(AW-REG_W){1'b0}}, cur_addr[REG_W-1:0]};

    wprot_addr_seq #(.AW(AW), .PW(PW)) i_seq (
        .clk(clk), .rst_n(rst_n), .step_i(op_valid_i), .first_i(op_first_i),
        .write_i(op_write_i), .array_i(op_array_i), .addr_i(op_addr_i),
        .cur_o(cur_addr)
    );

    wprot_policy #(.AW(AW), .DW(DW)) i_pol (
        .first_i(op_first_i), .array_i(op_array_i), .addr_i(cur_addr),
        .data_i(op_data_i), .latch_i(latch_q), .bp_i(bp), .lock_en_i(lock_en),
        .pin_i(wp_pin_i), .accept_o(accept), .arm_o(arm), .disarm_o(disarm),
        .hw_lock_o(hw_lock)
    );

    wprot_store #(.AW(AW), .DW(DW)) i_store (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .arm_i(arm), .disarm_i(disarm),
        .rd_en_i(op_valid_i & ~op_write_i), .array_i(op_array_i), .addr_i(cur_addr),
        .data_i(op_data_i), .latch_o(latch_q), .bp_o(bp), .lock_en_o(lock_en),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
    );

    // Registered verdict for each write byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_o       <= 1'b0;
            drop_o         <= 1'b0;
            commit_array_o <= 1'b0;
            commit_addr_o  <= '0;
            commit_data_o  <= '0;
        end else begin
            commit_o       <= wr_en;
            drop_o         <= wr_byte & ~accept;
            commit_array_o <= op_array_i;
            commit_addr_o  <= rep_addr;
            commit_data_o  <= op_data_i;
        end
    end
endmodule

// File: rtl/wprot_ctrl_chk.sv
// Property checker for wprot_ctrl. It is attached by bind and observes the
// ports plus the latch, protect and lock state inside the top module.
module wprot_ctrl_chk #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid_i,
    input logic          op_first_i,
    input logic          op_write_i,
    input logic          op_array_i,
    input logic [AW-1:0] op_addr_i,
    input logic [DW-1:0] op_data_i,
    input logic          commit_o,
    input logic          commit_array_o,
    input logic [AW-1:0] commit_addr_o,
    input logic          drop_o,
    input logic          rd_valid_o,
    input logic          latch_q,
    input logic [1:0]    bp,
    input logic          hw_lock
);
    logic fence_top;
    assign fence_top = (bp == 2'd3) || (bp == 2'd2 && commit_addr_o[AW-1]) ||
                       (bp == 2'd1 && commit_addr_o[AW-1] && commit_addr_o[AW-2]);

    assert_verdict_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && drop_o));
    assert_verdict_due_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_write_i) |=> (commit_o || drop_o));
    assert_arm_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_write_i && op_first_i && !op_array_i &&
         op_addr_i[2:0] == 3'd0 && op_data_i == 8'h80) |=> latch_q);
    assert_unarmed_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_write_i && op_array_i && !latch_q) |=> drop_o);
    assert_fault_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_write_i && op_first_i && !op_array_i &&
         op_addr_i[2:0] == 3'd5) |=> commit_o);
    assert_fence_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && commit_array_o) |-> !fence_top);
    assert_hw_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && !commit_array_o && commit_addr_o[2:0] >= 3'd1 &&
         commit_addr_o[2:0] <= 3'd4) |-> !$past(hw_lock));
    assert_read_due_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !op_write_i) |=> (rd_valid_o && !commit_o && !drop_o));
endmodule

bind wprot_ctrl wprot_ctrl_chk #(.AW(AW), .DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_first_i(op_first_i),
    .op_write_i(op_write_i), .op_array_i(op_array_i), .op_addr_i(op_addr_i),
    .op_data_i(op_data_i), .commit_o(commit_o), .commit_array_o(commit_array_o),
    .commit_addr_o(commit_addr_o), .drop_o(drop_o), .rd_valid_o(rd_valid_o),
    .latch_q(latch_q), .bp(bp), .hw_lock(hw_lock)
);

// File: tb/test_wprot_ctrl.sv
module test_wprot_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_pin_i = 1'b0;
    logic       op_valid_i = 1'b0, op_first_i = 1'b0, op_write_i = 1'b0, op_array_i = 1'b0;
    logic [7:0] op_addr_i = '0, op_data_i = '0;
    logic       commit_o, commit_array_o, drop_o, rd_valid_o;
    logic [7:0] commit_addr_o, commit_data_o, rd_data_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model
    logic [7:0] m_mem [256];
    logic [7:0] m_reg [8];
    bit         m_latch;
    logic [7:0] m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    wprot_ctrl i_wprot_ctrl (
        .clk(clk), .rst_n(rst_n), .wp_pin_i(wp_pin_i), .op_valid_i(op_valid_i),
        .op_first_i(op_first_i), .op_write_i(op_write_i), .op_array_i(op_array_i),
        .op_addr_i(op_addr_i), .op_data_i(op_data_i), .commit_o(commit_o),
        .commit_array_o(commit_array_o), .commit_addr_o(commit_addr_o),
        .commit_data_o(commit_data_o), .drop_o(drop_o), .rd_valid_o(rd_valid_o),
        .rd_data_o(rd_data_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit fenced(input logic [1:0] bp, input logic [7:0] a);
        if (bp == 2'd0) return 1'b0;
        if (bp == 2'd1) return a >= 8'hC0;
        if (bp == 2'd2) return a >= 8'h80;
        return 1'b1;
    endfunction

    function automatic bit expect_accept(input bit first, input bit arr,
                                         input logic [7:0] a, input logic [7:0] d);
        bit hw;
        hw = wp_pin_i && m_reg[1][7];
        if (arr) return m_latch && !fenced(m_reg[1][1:0], a);
        if (!first) return 1'b0;
        case (a[2:0])
            3'd0:         return (d == 8'h80) || (d == 8'h00);
            3'd5, 3'd6:   return 1'b1;
            3'd7:         return 1'b0;
            default:      return m_latch && !hw;
        endcase
    endfunction

    function automatic logic [7:0] expect_read(input bit arr, input logic [7:0] a);
        if (arr) return m_mem[a];
        if (a[2:0] == 3'd0) return {m_latch, 7'b0};
        if (a[2:0] == 3'd7) return 8'h00;
        return m_reg[a[2:0]];
    endfunction

    // one byte operation: drive on a falling edge, check on the next
    task automatic op(input bit first, input bit wr, input bit arr,
                      input logic [7:0] a, input logic [7:0] d, input string req);
        logic [7:0] cur, exp_addr, exp_rd;
        bit acc;
        cur = first ? a : m_ptr;
        acc = expect_accept(first, arr, cur, d);
        exp_rd = expect_read(arr, cur);
        exp_addr = arr ? cur : {5'b0, cur[2:0]};
        op_valid_i = 1'b1; op_first_i = first; op_write_i = wr;
        op_array_i = arr; op_addr_i = a; op_data_i = d;
        @(negedge clk);
        if (wr) begin
            check(commit_o == acc && drop_o == !acc, req, {commit_o, drop_o}, {acc, !acc});
            if (acc) check(commit_addr_o == exp_addr && commit_data_o == d &&
                           commit_array_o == arr, req, commit_addr_o, exp_addr);
            if (acc) begin
                if (arr) m_mem[cur] = d;
                else if (cur[2:0] == 3'd0) m_latch = (d == 8'h80);
                else m_reg[cur[2:0]] = d;
            end
        end else begin
            check(rd_valid_o && rd_data_o == exp_rd, req, rd_data_o, exp_rd);
        end
        if (arr && wr) m_ptr = {cur[7:4], cur[3:0] + 4'd1};
        else if (arr)  m_ptr = cur + 8'd1;
        else           m_ptr = cur;
        op_valid_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) m_mem[i] = '0;
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_latch = 0; m_ptr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!commit_o && !drop_o && !rd_valid_o, "R1", {commit_o, drop_o, rd_valid_o}, 0);
        op(1, 0, 0, 8'h00, 0, "R1 latch read");
        op(1, 0, 0, 8'h01, 0, "R1 cfg1 read");
        op(1, 0, 1, 8'h42, 0, "R1 array read");
        // R3: unarmed writes dropped
        op(1, 1, 1, 8'h10, 8'h5A, "R3 array");
        op(1, 1, 0, 8'h01, 8'h03, "R3 cfg1");
        op(1, 1, 0, 8'h04, 8'h77, "R3 cfg4");
        op(1, 0, 1, 8'h10, 0, "R3 readback");
        // R4: fault and reset-status always open
        op(1, 1, 0, 8'h05, 8'hAA, "R4 fault");
        op(1, 1, 0, 8'h06, 8'h55, "R4 rstat");
        op(1, 0, 0, 8'h05, 0, "R4 readback");
        // R2: latch arm/disarm
        op(1, 1, 0, 8'h00, 8'h81, "R2 illegal");
        op(1, 0, 0, 8'h00, 0, "R2 still clear");
        op(1, 1, 0, 8'h00, 8'h80, "R2 arm");
        op(1, 0, 0, 8'h00, 0, "R2 armed");
        op(1, 1, 0, 8'h00, 8'h40, "R2 illegal armed");
        op(1, 0, 0, 8'h00, 0, "R2 still armed");
        // R9: single byte per register write, register 7 absent
        op(1, 1, 0, 8'h02, 8'h11, "R9 first");
        op(0, 1, 0, 8'h00, 8'h22, "R9 extra");
        op(1, 0, 0, 8'h02, 0, "R9 readback");
        op(1, 1, 0, 8'h07, 8'h33, "R9 reg7");
        // R5: protect field sweep
        for (int b = 0; b < 4; b++) begin
            op(1, 1, 0, 8'h01, b[7:0], "R5 set bp");
            op(1, 1, 1, 8'h00, 8'hA0 + b[7:0], "R5 00");
            op(1, 1, 1, 8'h7F, 8'hB0 + b[7:0], "R5 7F");
            op(1, 1, 1, 8'h80, 8'hC0 + b[7:0], "R5 80");
            op(1, 1, 1, 8'hBF, 8'hD0 + b[7:0], "R5 BF");
            op(1, 1, 1, 8'hC0, 8'hE0 + b[7:0], "R5 C0");
            op(1, 1, 1, 8'hFF, 8'hF0 + b[7:0], "R5 FF");
        end
        // R8: page wrap with per-byte check
        op(1, 1, 0, 8'h01, 8'h01, "R8 bp1");
        op(1, 1, 1, 8'hBE, 8'h01, "R8 p0");
        for (int k = 1; k < 16; k++) op(0, 1, 1, 8'h00, 8'h01 + k[7:0], "R8 page");
        op(1, 1, 1, 8'hFE, 8'h91, "R8 fenced page");
        op(0, 1, 1, 8'h00, 8'h92, "R8 fenced wrap");
        op(1, 0, 1, 8'hB0, 0, "R8 wrapped byte");
        op(1, 0, 1, 8'hC0, 0, "R8 next page untouched");
        // R6/R7: hardware lock
        op(1, 1, 0, 8'h01, 8'h80, "R6 lock en, bp0");
        wp_pin_i = 1'b1;
        op(1, 1, 0, 8'h01, 8'h00, "R6 cfg1 frozen");
        op(1, 1, 0, 8'h03, 8'h44, "R6 cfg3 frozen");
        op(1, 0, 0, 8'h01, 0, "R6 cfg1 readback");
        op(1, 1, 1, 8'h20, 8'h66, "R7 array open");
        op(1, 1, 1, 8'hF0, 8'h67, "R7 array open top");
        op(1, 1, 0, 8'h05, 8'h12, "R4 under lock");
        wp_pin_i = 1'b0;
        op(1, 1, 0, 8'h03, 8'h45, "R6 pin low");
        // R11: read wrap
        op(1, 0, 1, 8'hFE, 0, "R11 FE");
        op(0, 0, 1, 8'h00, 0, "R11 FF");
        op(0, 0, 1, 8'h00, 0, "R11 00");
        op(1, 0, 0, 8'h03, 0, "R11 reg");
        op(0, 0, 0, 8'h00, 0, "R11 reg repeat");
        // R2/R3: disarm
        op(1, 1, 0, 8'h00, 8'h00, "R2 disarm");
        op(1, 1, 1, 8'h21, 8'h68, "R3 after disarm");
        // randomized mix
        for (int n = 0; n < 1500; n++) begin
            bit f, w, ar;
            logic [7:0] a, d;
            int sel;
            f  = ($urandom % 3) != 0;
            w  = ($urandom % 3) != 0;
            ar = $urandom % 2;
            a  = $urandom;
            d  = $urandom;
            sel = $urandom % 4;
            if (!ar && a[2:0] == 3'd0) d = (sel == 0) ? 8'h80 : (sel == 1) ? 8'h00 : d;
            if (!ar && a[2:0] == 3'd1 && sel < 2) d = {d[7], 5'b0, d[1:0]};
            wp_pin_i = ($urandom % 4) == 0;
            op(f, w, ar, a, d, "R10 random");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule